// File: doc/BRIEF.md
# Asynchronous SRAM Access Sequencer

This block sits between an on-chip requester and an external asynchronous static RAM that is eight bits wide and has nineteen address lines. The requester raises a level request carrying a direction flag, a word address and, for stores, one data byte. The sequencer then plays out the pin sequence the memory expects on its active-low select, store strobe and output-enable lines, its address bus and its bidirectional data bus. The data bus is presented as a separate output value, input value and tristate enable, to be joined at the pad. Every phase lasts a whole number of system-clock cycles, and each length is a parameter, so the nanosecond minimums of the memory are met at the chosen clock rate.

A load keeps select and output enable low and the store strobe high for the read phase. The returned byte is captured on the last clock edge of that phase. The select and output enable then return high, and the sequencer waits out a turnaround gap so that the memory's slow-releasing output drivers have let go of the bus before anyone drives it again. A store holds output enable high for its whole duration, which allows the shorter strobe width. It drives the data bus together with the strobe and keeps driving it for one cycle after the strobe rises, which covers the zero-time data hold. Between transactions the memory is deselected and the bus is left undriven, which puts the memory in standby.

Top module: `asram_ctrl`

## Requirements
- R1: During reset, and whenever no transaction is in progress, the select, strobe and output-enable pins are all high (1), the tristate enable is 0 and the acknowledge is 0.
- R2: A load (request with direction flag 0) drives select 0, output enable 0 and strobe 1 for exactly READ_CYC consecutive cycles, and never enables the data-bus driver during that time.
- R3: The byte presented on the data-bus input during the last cycle of the read phase appears on the read-data output when the acknowledge goes high, and it stays there until the next load.
- R4: A store (direction flag 1) drives the strobe low for exactly max(WP_CYC, DW_CYC) consecutive cycles with select low, and output enable stays high for the whole store.
- R5: The data-bus driver is enabled, carrying the request byte, in every cycle in which the strobe is low, and also in the single cycle after the strobe rises. It is disabled the cycle after that.
- R6: The data-bus driver is never enabled in a cycle in which the memory's outputs are enabled (select low, strobe high, output enable low).
- R7: After a load, at least TURN_CYC cycles with the data-bus driver disabled pass between output enable rising and the next cycle in which the driver is enabled.
- R8: Every accepted request produces exactly one acknowledge pulse, one cycle long. With the request raised while the sequencer is idle, the acknowledge is first seen READ_CYC+1 clock edges later for a load and max(WP_CYC, DW_CYC)+1 edges later for a store.
- R9: A request is accepted only while the sequencer is idle. Changes to the request address, direction or data during a transaction have no effect on the memory pins of that transaction.
- R10: The memory address bus stays constant in every cycle that select is low during a transaction, and covers the full range from 0x00000 to 0x7FFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| req | input | 1 | Request, held high until acknowledged |
| req_we | input | 1 | 1 = store, 0 = load |
| req_addr | input | 19 | Word address |
| req_wdata | input | 8 | Store data |
| ack | output | 1 | One-cycle completion pulse |
| rdata | output | 8 | Captured load data |
| mem_ce_n | output | 1 | Memory select, active low |
| mem_we_n | output | 1 | Memory store strobe, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_addr | output | 19 | Memory address |
| mem_dq_out | output | 8 | Data toward the memory |
| mem_dq_oe | output | 1 | Tristate enable for mem_dq_out |
| mem_dq_in | input | 8 | Data from the memory bus |

## Verification
The bench runs the sequencer against a behavioural memory that decodes the pin truth table, latches stored bytes on the strobe's rising edge and floats its outputs when they are not enabled. One table of loads and stores covers both ends of the address range, all-ones and all-zero bytes, and an overwrite. These show whether addresses and data reach the right cell, and whether a later store replaces an earlier one rather than being lost. The store strobe is deliberately set shorter than the data-setup length, which separates the correct pulse of max(WP_CYC, DW_CYC) from either parameter alone. A load followed at once by a store exercises the bus turnaround. Changing the request fields in the middle of a load shows whether they are only sampled when idle. A monitor counts the strobe and output-enable widths and flags any cycle in which both sides drive the bus.

// File: rtl/asram_ctrl_pkg.sv
package asram_ctrl_pkg;

  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_LOAD   = 3'd1,
    PH_GAP    = 3'd2,
    PH_STROBE = 3'd3,
    PH_HOLD   = 3'd4
  } phase_e;

  function automatic int unsigned umax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/asram_phase_timer.sv
module asram_phase_timer #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             last
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load) begin
      cnt_d = load_val;
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign last = (cnt_q == '0);

endmodule

// File: rtl/asram_seq.sv
module asram_seq
  import asram_ctrl_pkg::*;
#(
  parameter int unsigned READ_CYC = 2,
  parameter int unsigned WP_CYC   = 1,
  parameter int unsigned DW_CYC   = 1,
  parameter int unsigned TURN_CYC = 1,
  parameter int unsigned CNT_W    = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic             req_we,
  input  logic             last,
  output logic             tmr_load,
  output logic [CNT_W-1:0] tmr_val,
  output logic             accept,
  output logic             capture,
  output logic             ack,
  output logic             ce_n,
  output logic             we_n,
  output logic             oe_n,
  output logic             dq_oe
);

  localparam int unsigned PULSE_CYC = umax(WP_CYC, DW_CYC);
  localparam logic [CNT_W-1:0] LOAD_LEN  = CNT_W'(READ_CYC - 1);
  localparam logic [CNT_W-1:0] PULSE_LEN = CNT_W'(PULSE_CYC - 1);
  localparam logic [CNT_W-1:0] GAP_LEN   = CNT_W'(TURN_CYC - 1);

  phase_e ph_q, ph_d;
  logic   ce_n_d, we_n_d, oe_n_d, dq_oe_d, ack_d;

  // next-phase logic
  always_comb begin
    ph_d     = ph_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    accept   = 1'b0;
    capture  = 1'b0;
    unique case (ph_q)
      PH_IDLE: begin
        if (req) begin
          accept   = 1'b1;
          tmr_load = 1'b1;
          if (req_we) begin
            ph_d    = PH_STROBE;
            tmr_val = PULSE_LEN;
          end else begin
            ph_d    = PH_LOAD;
            tmr_val = LOAD_LEN;
          end
        end
      end
      PH_LOAD: begin
        if (last) begin
          capture  = 1'b1;
          tmr_load = 1'b1;
          tmr_val  = GAP_LEN;
          ph_d     = PH_GAP;
        end
      end
      PH_GAP: begin
        if (last) begin
          ph_d = PH_IDLE;
        end
      end
      PH_STROBE: begin
        if (last) begin
          ph_d = PH_HOLD;
        end
      end
      PH_HOLD: begin
        ph_d = PH_IDLE;
      end
      default: begin
        ph_d = PH_IDLE;
      end
    endcase
  end

  // pin decode from the next phase, so pins are registered
  always_comb begin
    ce_n_d  = !((ph_d == PH_LOAD) || (ph_d == PH_STROBE) || (ph_d == PH_HOLD));
    we_n_d  = (ph_d != PH_STROBE);
    oe_n_d  = (ph_d != PH_LOAD);
    dq_oe_d = (ph_d == PH_STROBE) || (ph_d == PH_HOLD);
    ack_d   = capture || ((ph_q == PH_STROBE) && (ph_d == PH_HOLD));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_IDLE;
      ce_n  <= 1'b1;
      we_n  <= 1'b1;
      oe_n  <= 1'b1;
      dq_oe <= 1'b0;
      ack   <= 1'b0;
    end else begin
      ph_q  <= ph_d;
      ce_n  <= ce_n_d;
      we_n  <= we_n_d;
      oe_n  <= oe_n_d;
      dq_oe <= dq_oe_d;
      ack   <= ack_d;
    end
  end

  // R1: deselected means nothing active and bus released
  a_r1_standby_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ce_n |-> (we_n && oe_n && !dq_oe));

  // R4: output enable stays high while the strobe is low
  a_r4_strobe_oe_high: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> (oe_n && !ce_n));

  // R5: data driven during the strobe
  a_r5_drive_in_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> dq_oe);

  // R5: data still driven in the cycle the strobe rises
  a_r5_hold_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(we_n) |-> (dq_oe && !ce_n));

  // R6: never drive while memory outputs are enabled
  a_r6_no_contention: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> oe_n);

  // R8: acknowledge is a single-cycle pulse
  a_r8_ack_single: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !ack);

endmodule

// File: rtl/asram_dpath.sv
module asram_dpath #(
  parameter int unsigned ADDR_W = 19,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              capture,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] dq_in,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] dq_out,
  output logic [DATA_W-1:0] rdata
);

  logic [ADDR_W-1:0] addr_d;
  logic [DATA_W-1:0] wdat_d;
  logic [DATA_W-1:0] rdat_d;

  always_comb begin
    addr_d = accept  ? req_addr  : addr;
    wdat_d = accept  ? req_wdata : dq_out;
    rdat_d = capture ? dq_in     : rdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr   <= '0;
      dq_out <= '0;
      rdata  <= '0;
    end else begin
      addr   <= addr_d;
      dq_out <= wdat_d;
      rdata  <= rdat_d;
    end
  end

endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl
  import asram_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W   = 19,
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned READ_CYC = 2,
  parameter int unsigned WP_CYC   = 1,
  parameter int unsigned DW_CYC   = 1,
  parameter int unsigned TURN_CYC = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              ack,
  output logic [DATA_W-1:0] rdata,
  output logic              mem_ce_n,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in
);

  localparam int unsigned LONGEST = umax(umax(READ_CYC, umax(WP_CYC, DW_CYC)), TURN_CYC);
  localparam int unsigned CNT_W   = $clog2(LONGEST) + 1;

  logic             tmr_load;
  logic [CNT_W-1:0] tmr_val;
  logic             tmr_last;
  logic             accept;
  logic             capture;

  asram_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .last     (tmr_last)
  );

  asram_seq #(
    .READ_CYC (READ_CYC),
    .WP_CYC   (WP_CYC),
    .DW_CYC   (DW_CYC),
    .TURN_CYC (TURN_CYC),
    .CNT_W    (CNT_W)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .req      (req),
    .req_we   (req_we),
    .last     (tmr_last),
    .tmr_load (tmr_load),
    .tmr_val  (tmr_val),
    .accept   (accept),
    .capture  (capture),
    .ack      (ack),
    .ce_n     (mem_ce_n),
    .we_n     (mem_we_n),
    .oe_n     (mem_oe_n),
    .dq_oe    (mem_dq_oe)
  );

  asram_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dpath (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (accept),
    .capture   (capture),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .dq_in     (mem_dq_in),
    .addr      (mem_addr),
    .dq_out    (mem_dq_out),
    .rdata     (rdata)
  );

  // R10: address held while the memory is selected
  a_r10_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr));

  // R5: store data held while the bus is driven
  a_r5_data_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_dq_oe && $past(mem_dq_oe)) |-> $stable(mem_dq_out));

endmodule

// File: tb/asram_ctrl_tb.sv
module asram_ctrl_tb;

  localparam int unsigned RC = 3;
  localparam int unsigned WP = 2;
  localparam int unsigned DW = 3;
  localparam int unsigned TC = 2;
  localparam int unsigned PC = (WP > DW) ? WP : DW;

  logic        clk;
  logic        rst_n;
  logic        req;
  logic        req_we;
  logic [18:0] req_addr;
  logic [7:0]  req_wdata;
  logic        ack;
  logic [7:0]  rdata;
  logic        ce_n, we_n, oe_n, dq_oe;
  logic [18:0] maddr;
  logic [7:0]  dq_out;
  logic [7:0]  bus;
  logic [7:0]  model_q;
  logic        model_drv;

  int checks = 0;
  int errors = 0;

  asram_ctrl #(
    .READ_CYC (RC), .WP_CYC (WP), .DW_CYC (DW), .TURN_CYC (TC)
  ) u_dut (
    .clk (clk), .rst_n (rst_n), .req (req), .req_we (req_we),
    .req_addr (req_addr), .req_wdata (req_wdata), .ack (ack), .rdata (rdata),
    .mem_ce_n (ce_n), .mem_we_n (we_n), .mem_oe_n (oe_n), .mem_addr (maddr),
    .mem_dq_out (dq_out), .mem_dq_oe (dq_oe), .mem_dq_in (bus)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // behavioural memory: unwritten cells read as 0x00
  logic [7:0] mem [logic [18:0]];
  assign model_drv = !ce_n && we_n && !oe_n;
  always @* model_q = mem.exists(maddr) ? mem[maddr] : 8'h00;
  assign bus = dq_oe ? dq_out : (model_drv ? model_q : 8'hzz);
  always @(posedge we_n) if (rst_n && !ce_n) mem[maddr] = bus;

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", rq, act, exp, $time);
    end
  endtask

  // pin monitor
  int  wlow, rlow, gap;
  bit  after_load;
  logic        we_prev, oe_prev, ce_prev;
  logic [18:0] addr_prev;
  always @(negedge clk) begin
    if (!rst_n) begin
      wlow = 0; rlow = 0; gap = 0; after_load = 0;
      we_prev = 1; oe_prev = 1; ce_prev = 1; addr_prev = maddr;
    end else begin
      if (dq_oe && model_drv) chk(0, "R6 contention", 1, 0);
      if (!we_n) begin
        wlow++;
        chk(oe_n && !ce_n && dq_oe, "R4/R5 strobe pins", {oe_n, ce_n, dq_oe}, 3'b101);
      end else if (!we_prev) begin
        chk(wlow == PC, "R4 strobe width", wlow, PC);
        chk(dq_oe, "R5 hold drive", dq_oe, 1);
        wlow = 0;
      end
      if (we_n && we_prev && !dq_oe && !ce_n && oe_n) chk(0, "R5 drive released", 0, 1);
      if (!oe_n) begin
        rlow++;
        chk(!ce_n && we_n && !dq_oe, "R2 load pins", {ce_n, we_n, dq_oe}, 3'b010);
      end else if (!oe_prev) begin
        chk(rlow == RC, "R2 load width", rlow, RC);
        rlow = 0; gap = 0; after_load = 1;
      end
      if (after_load) begin
        if (dq_oe) begin
          chk(gap >= TC, "R7 turnaround", gap, TC);
          after_load = 0;
        end else if (oe_n) gap++;
      end
      if (!ce_n && !ce_prev) chk(maddr == addr_prev, "R10 addr stable", maddr, addr_prev);
      we_prev = we_n; oe_prev = oe_n; ce_prev = ce_n; addr_prev = maddr;
    end
  end

  // one transaction; returns edges to ack and captured data
  task automatic txn(input logic w, input logic [18:0] a, input logic [7:0] d,
                     output int lat, output logic [7:0] rd);
    @(negedge clk);
    req = 1'b1; req_we = w; req_addr = a; req_wdata = d;
    lat = 0;
    do begin
      @(negedge clk);
      lat++;
    end while (!ack && lat < 50);
    rd = rdata;
    req = 1'b0;
    @(negedge clk);
    chk(!ack, "R8 ack one cycle", ack, 0);
  endtask

  task automatic settle();
    repeat (TC + 3) @(negedge clk);
  endtask

  // {we, addr, wdata, expected load byte}
  localparam logic [35:0] VEC [0:8] = '{
    {1'b1, 19'h00000, 8'hA5, 8'h00},
    {1'b1, 19'h7FFFF, 8'h3C, 8'h00},
    {1'b1, 19'h12345, 8'hFF, 8'h00},
    {1'b0, 19'h00000, 8'h00, 8'hA5},
    {1'b0, 19'h7FFFF, 8'h00, 8'h3C},
    {1'b1, 19'h12345, 8'h00, 8'h00},
    {1'b0, 19'h12345, 8'h00, 8'h00},
    {1'b1, 19'h55555, 8'h5A, 8'h00},
    {1'b0, 19'h55555, 8'h00, 8'h5A}
  };

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int lat;
    logic [7:0] rd;
    rst_n = 1'b0; req = 1'b0; req_we = 1'b0; req_addr = '0; req_wdata = '0;
    repeat (3) @(negedge clk);
    // R1 during reset
    chk(ce_n && we_n && oe_n && !dq_oe && !ack, "R1 reset pins",
        {ce_n, we_n, oe_n, dq_oe, ack}, 5'b11100);
    @(posedge clk); #1 rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(ce_n && we_n && oe_n && !dq_oe && !ack, "R1 idle pins",
        {ce_n, we_n, oe_n, dq_oe, ack}, 5'b11100);

    // table walk: R2 R3 R4 R8 R10
    for (int i = 0; i < 9; i++) begin
      txn(VEC[i][35], VEC[i][34:16], VEC[i][15:8], lat, rd);
      if (VEC[i][35]) begin
        chk(lat == PC + 1, "R8 store latency", lat, PC + 1);
      end else begin
        chk(lat == RC + 1, "R8 load latency", lat, RC + 1);
        chk(rd == VEC[i][7:0], "R3 load data", rd, VEC[i][7:0]);
      end
      settle();
      chk(ce_n && !dq_oe, "R1 back to standby", {ce_n, dq_oe}, 2'b10);
    end

    // R3: rdata persists across a store
    txn(1'b1, 19'h00001, 8'h77, lat, rd);
    settle();
    chk(rdata == 8'h5A, "R3 rdata held", rdata, 8'h5A);

    // R7: load then store immediately
    txn(1'b0, 19'h00001, 8'h00, lat, rd);
    chk(rd == 8'h77, "R3 load after store", rd, 8'h77);
    txn(1'b1, 19'h00002, 8'hC3, lat, rd);
    settle();
    txn(1'b0, 19'h00002, 8'h00, lat, rd);
    chk(rd == 8'hC3, "R7 store after turnaround", rd, 8'hC3);
    settle();

    // R9: fields changed mid-load are ignored
    @(negedge clk);
    req = 1'b1; req_we = 1'b0; req_addr = 19'h00000; req_wdata = 8'h11;
    @(negedge clk);
    req_we = 1'b1; req_addr = 19'h7FFFF; req_wdata = 8'hEE;
    @(negedge clk);
    chk(maddr == 19'h00000 && we_n, "R9 pins unchanged", {we_n, maddr}, {1'b1, 19'h00000});
    lat = 0;
    while (!ack && lat < 50) begin @(negedge clk); lat++; end
    chk(rdata == 8'hA5, "R9 load data kept", rdata, 8'hA5);
    req = 1'b0;
    settle();
    txn(1'b0, 19'h7FFFF, 8'h00, lat, rd);
    chk(rd == 8'h3C, "R9 no stray store", rd, 8'h3C);
    settle();

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule